// File: doc/BRIEF.md
# Fast Fault Shutdown Sequencer

This block supervises a shared, active-low shutdown line that carries an external RC network and may also be driven low by other devices or by a controller. When a fault trip arrives, the gate-drive enable falls in the same cycle through a combinational path. The block then turns on an open-drain pull-down on the shared line. It holds that pull-down until the line is sensed below its lower logic threshold. It then lets go of the line so the external pull-up can recharge the capacitor. The drivers stay disabled until the line is sensed above its upper threshold. The recovery time therefore comes entirely from the external RC network, and the fault reaction never waits for that network.

A low level applied to the line from outside is never latched. The drivers follow the line, so pulsing the line can chop the PWM. A hysteretic supply monitor compares a sampled supply code against separate turn-on and turn-off codes. While the supply is low, the block keeps both outputs quiet and ignores the fault input. The threshold flags come from sampled comparators outside this block.

Top module: `shutdown_sequencer`

## Requirements
- R1: While reset is asserted, and in the cycles after it until the supply is declared good, `gate_en` and `od_pull_en` are both 0.
- R2: In every cycle in which `fault_trip` is 1 and the supply is good, `gate_en` is 0 in that same cycle, whatever the line flags show.
- R3: After a fault trip with a good supply, `od_pull_en` is 1 from the next clock edge. It stays 1 for as long as `line_low_flag` is 0.
- R4: While the pull-down is on and `line_low_flag` is 1 with no fault, `od_pull_en` returns to 0 at the next clock edge.
- R5: After the pull-down is released, `gate_en` stays 0 while `line_high_flag` is 0. `gate_en` becomes 1 one clock edge after `line_high_flag` is sampled as 1.
- R6: If the line drops (`line_high_flag` = 0) during normal running, `gate_en` falls in the same cycle and `od_pull_en` stays 0. `gate_en` returns one edge after `line_high_flag` is 1 again, so the drop is not latched.
- R7: A fault trip arriving while the pull-down is on, or while the block waits for the upper threshold, turns the pull-down on at the next edge.
- R8: The supply is declared good one edge after `supply_code` is at or above `ON_CODE`. It is declared bad one edge after `supply_code` is below `OFF_CODE`. Between the two codes it keeps its previous value. `ON_CODE` must exceed `OFF_CODE`.
- R9: While the supply is bad, `fault_trip` has no effect: `od_pull_en` stays 0.
- R10: Loss of supply forces `gate_en` to 0 in the cycle after the losing sample. It forces `od_pull_en` to 0 one edge later, from any state.
- R11: If the line is held low from outside after the pull-down is released, `gate_en` stays 0 and `od_pull_en` stays 0 for as long as `line_high_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_trip | input | 1 | Fault comparator trip, active high |
| line_low_flag | input | 1 | Shared line sensed below the lower logic threshold |
| line_high_flag | input | 1 | Shared line sensed above the upper logic threshold |
| supply_code | input | SUP_W | Sampled supply level code |
| od_pull_en | output | 1 | Enable for the open-drain pull-down on the shared line |
| gate_en | output | 1 | Enable for both gate-driver outputs |

## Verification
The bench builds the block with an 8-bit supply code, a turn-on code of 200 and a turn-off code of 180. This leaves a band of twenty codes in which the bench can park the supply to show that the monitor holds its previous decision in both directions. The bench drives the two threshold flags on their own, as the RC network would in time. This allows long holds above the lower threshold during the pull-down phase, long holds low by an outside driver, and re-trips during the release phase, each lasting as long as the scenario needs.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {
    ST_UVLO    = 2'd0,
    ST_RUN     = 2'd1,
    ST_PULL    = 2'd2,
    ST_RELEASE = 2'd3
  } fss_state_t;
endpackage

// File: rtl/fss_supply_monitor.sv
module fss_supply_monitor #(
  parameter int SUP_W   = 8,
  parameter int ON_CODE = 200,
  parameter int OFF_CODE = 180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_code,
  output logic             supply_ok
);
  localparam logic [SUP_W-1:0] OnC  = SUP_W'(ON_CODE);
  localparam logic [SUP_W-1:0] OffC = SUP_W'(OFF_CODE);

  initial begin
    assert (ON_CODE > OFF_CODE) else $error("turn-on code must exceed turn-off code");
  end

  logic ok_q, ok_d;

  always_comb begin
    ok_d = ok_q;
    if (!ok_q && (supply_code >= OnC)) ok_d = 1'b1;
    else if (ok_q && (supply_code < OffC)) ok_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign supply_ok = ok_q;

  // R8: hysteresis holds the decision inside the band
  p_hold_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && supply_code >= OffC) |=> ok_q);
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok_q && supply_code < OnC) |=> !ok_q);
endmodule

// File: rtl/fss_seq_core.sv
module fss_seq_core
  import fss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       fault_trip,
  input  logic       line_low_flag,
  input  logic       line_high_flag,
  output fss_state_t state,
  output logic       fault_live
);
  fss_state_t st_q, st_d;

  assign fault_live = fault_trip & supply_ok;

  always_comb begin
    st_d = st_q;
    if (!supply_ok) begin
      st_d = ST_UVLO;
    end else begin
      unique case (st_q)
        ST_UVLO: begin
          if (fault_trip)          st_d = ST_PULL;
          else if (line_high_flag) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (fault_trip)           st_d = ST_PULL;
          else if (!line_high_flag) st_d = ST_RELEASE;
        end
        ST_PULL: begin
          if (fault_trip)         st_d = ST_PULL;
          else if (line_low_flag) st_d = ST_RELEASE;
        end
        ST_RELEASE: begin
          if (fault_trip)          st_d = ST_PULL;
          else if (line_high_flag) st_d = ST_RUN;
        end
        default: st_d = ST_UVLO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_UVLO;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R7: a live fault always leads to the pull state
  p_fault_pulls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_live |=> (st_q == ST_PULL));
  // R9: a bad supply leads to the lockout state, never to pull
  p_uvlo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (st_q == ST_UVLO));
  // R4: release of the pull-down once the low threshold is seen
  p_release_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PULL && line_low_flag && !fault_trip && supply_ok) |=> (st_q == ST_RELEASE));
endmodule

// File: rtl/fss_out_gate.sv
module fss_out_gate
  import fss_pkg::*;
(
  input  fss_state_t state,
  input  logic       supply_ok,
  input  logic       fault_live,
  input  logic       line_high_flag,
  output logic       od_pull_en,
  output logic       gate_en
);
  always_comb begin
    od_pull_en = (state == ST_PULL);
    gate_en    = (state == ST_RUN) && supply_ok && line_high_flag && !fault_live;
  end
endmodule

// File: rtl/shutdown_sequencer.sv
module shutdown_sequencer
  import fss_pkg::*;
#(
  parameter int SUP_W    = 8,
  parameter int ON_CODE  = 200,
  parameter int OFF_CODE = 180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_trip,
  input  logic             line_low_flag,
  input  logic             line_high_flag,
  input  logic [SUP_W-1:0] supply_code,
  output logic             od_pull_en,
  output logic             gate_en
);
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic       supply_ok;
  logic       fault_live;
  fss_state_t state;

  fss_supply_monitor #(
    .SUP_W(SUP_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)
  ) u_mon (
    .clk(clk), .rst_n(rst_n_i), .supply_code(supply_code), .supply_ok(supply_ok)
  );

  fss_seq_core u_core (
    .clk(clk), .rst_n(rst_n_i), .supply_ok(supply_ok), .fault_trip(fault_trip),
    .line_low_flag(line_low_flag), .line_high_flag(line_high_flag),
    .state(state), .fault_live(fault_live)
  );

  fss_out_gate u_gate (
    .state(state), .supply_ok(supply_ok), .fault_live(fault_live),
    .line_high_flag(line_high_flag), .od_pull_en(od_pull_en), .gate_en(gate_en)
  );

  // R3: drivers never enabled while the line is being pulled down
  p_pull_excl_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    od_pull_en |-> !gate_en);
  // R5: re-enable only with the line above the upper threshold
  p_reenable_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    gate_en |-> line_high_flag);
  // R2: a live fault blocks the drivers in the same cycle
  p_fault_block_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fault_trip && supply_ok) |-> !gate_en);
endmodule

// File: tb/shutdown_sequencer_test.sv
module shutdown_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fault_trip;
  logic       line_low_flag;
  logic       line_high_flag;
  logic [7:0] supply_code;
  logic       od_pull_en;
  logic       gate_en;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  shutdown_sequencer #(.SUP_W(8), .ON_CODE(200), .OFF_CODE(180)) uut (
    .clk(clk), .rst_n(rst_n), .fault_trip(fault_trip),
    .line_low_flag(line_low_flag), .line_high_flag(line_high_flag),
    .supply_code(supply_code), .od_pull_en(od_pull_en), .gate_en(gate_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_line(input logic lo, input logic hi);
    line_low_flag  = lo;
    line_high_flag = hi;
  endtask

  task automatic t_reset();
    chk("R1 gate in reset", gate_en, 1'b0);
    chk("R1 pull in reset", od_pull_en, 1'b0);
    rst_n = 1'b1;
    ticks(3);
    chk("R1 gate before supply", gate_en, 1'b0);
  endtask

  task automatic t_uvlo_fault();
    fault_trip = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 pull ignored", od_pull_en, 1'b0);
      chk("R9 gate off", gate_en, 1'b0);
    end
    fault_trip = 1'b0;
  endtask

  task automatic t_power_up();
    supply_code = 8'd220;
    tick();
    chk("R8 not yet running", gate_en, 1'b0);
    tick();
    chk("R8 running after on code", gate_en, 1'b1);
  endtask

  task automatic t_fault_cycle();
    fault_trip = 1'b1;
    #2;
    chk("R2 same-cycle off", gate_en, 1'b0);
    tick();
    chk("R3 pull on", od_pull_en, 1'b1);
    fault_trip = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 pull held", od_pull_en, 1'b1);
      chk("R3 gate off", gate_en, 1'b0);
    end
    set_line(1'b1, 1'b0);
    tick();
    chk("R4 pull released", od_pull_en, 1'b0);
    set_line(1'b0, 1'b0);
    ticks(2);
    chk("R5 gate waits", gate_en, 1'b0);
    set_line(1'b0, 1'b1);
    #2;
    chk("R5 no same-cycle enable", gate_en, 1'b0);
    tick();
    chk("R5 gate back", gate_en, 1'b1);
  endtask

  task automatic t_chop();
    for (int k = 0; k < 2; k++) begin
      set_line(1'b0, 1'b0);
      #2;
      chk("R6 gate off at once", gate_en, 1'b0);
      tick();
      chk("R6 gate off", gate_en, 1'b0);
      chk("R6 no pull", od_pull_en, 1'b0);
      set_line(1'b0, 1'b1);
      tick();
      chk("R6 gate follows line", gate_en, 1'b1);
    end
  endtask

  task automatic t_refault();
    fault_trip = 1'b1;
    tick();
    fault_trip = 1'b0;
    set_line(1'b1, 1'b0);
    tick();
    chk("R7 released", od_pull_en, 1'b0);
    set_line(1'b0, 1'b0);
    fault_trip = 1'b1;
    tick();
    chk("R7 pull again", od_pull_en, 1'b1);
    fault_trip = 1'b0;
    set_line(1'b1, 1'b0);
    tick();
    set_line(1'b0, 1'b1);
    tick();
    chk("R7 recovered", gate_en, 1'b1);
  endtask

  task automatic t_held_low();
    fault_trip = 1'b1;
    tick();
    fault_trip = 1'b0;
    set_line(1'b1, 1'b0);
    tick();
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R11 gate held off", gate_en, 1'b0);
      chk("R11 pull off", od_pull_en, 1'b0);
    end
    set_line(1'b0, 1'b1);
    tick();
    chk("R11 recovered", gate_en, 1'b1);
  endtask

  task automatic t_supply();
    supply_code = 8'd190;
    ticks(2);
    chk("R8 stays on in band", gate_en, 1'b1);
    supply_code = 8'd170;
    tick();
    chk("R10 gate off after loss", gate_en, 1'b0);
    supply_code = 8'd190;
    ticks(2);
    chk("R8 stays off in band", gate_en, 1'b0);
    supply_code = 8'd210;
    ticks(2);
    chk("R8 back on", gate_en, 1'b1);
    fault_trip = 1'b1;
    tick();
    fault_trip = 1'b0;
    chk("R10 pull before loss", od_pull_en, 1'b1);
    supply_code = 8'd0;
    tick();
    tick();
    chk("R10 pull dropped", od_pull_en, 1'b0);
    chk("R10 gate off", gate_en, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    fault_trip = 1'b0;
    supply_code = 8'd0;
    set_line(1'b0, 1'b1);
    ticks(3);
    t_reset();
    t_uvlo_fault();
    t_power_up();
    t_fault_cycle();
    t_chop();
    t_refault();
    t_held_low();
    t_supply();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule